// File: doc/BRIEF.md
# Vector Register Busy Scoreboard

This block keeps one busy flag for each physical register of a SIMD vector register file. An issue stage asks it whether every vector source register of an instruction is free. When the answer is no, it raises a read-after-write stall indication. When an instruction issues, the block reserves that instruction's destination registers. It later frees them, either after a bypass delay counted from execute completion or one clock after load data comes back.

Register numbers arrive as logical indices relative to a per-wavefront base. An operand wider than four bytes spans several consecutive registers, and every one of those registers is checked or reserved. Two kinds of issue do not reserve anything: atomics that return no value, and loads whose lane mask is all zero. Neither of these ever writes its destinations, so a reservation would never be freed.

Top module: `vreg_busy_board`

## Requirements
- R1: After reset every register is free. A query with no vector source flagged returns ready.
- R2: The physical register is the port's base plus the logical index. An operand of at most 4 bytes covers one register. A larger operand covers size/4 consecutive registers (sizes are given in bytes).
- R3: `q_ready` is low and `raw_stall` is high in the same cycle exactly when some covered register of a source with its `q_vec` bit set is busy. Sources whose bit is clear have no effect.
- R4: An accepted issue marks every covered register of every flagged destination busy from the next clock edge. Only an issue can set a busy flag.
- R5: An issue with `iss_atomic`=1 and `iss_atomic_ret`=0 reserves nothing.
- R6: An issue with `iss_load`=1 and an all-zero `iss_exec` reserves nothing.
- R7: Execute completion of an instruction that is not a load, atomic or memory sync frees its destinations at the SP_LEN-th edge after the edge that samples it when `ex_widest` is at most 4 bytes, and at the DP_LEN-th edge otherwise.
- R8: Execute completion flagged as load, atomic or memory sync frees nothing.
- R9: A load return frees its destinations at the edge after the one that samples it.
- R10: A reservation hitting a register at the same edge as a pending or expiring release keeps the register busy and cancels that release.
- R11: Every flagged range on the issue and query ports must lie below NREGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_base | input | 8 | Wavefront base for the query |
| q_vec | input | 3 | Per-source flag: operand is a vector register |
| q_idx | input | 24 | Logical source indices, 8 bits each |
| q_size | input | 15 | Source sizes in bytes, 5 bits each |
| q_ready | output | 1 | All flagged sources free |
| raw_stall | output | 1 | Read-after-write stall indication |
| iss_valid | input | 1 | Issue strobe |
| iss_base | input | 8 | Wavefront base for the issue |
| iss_dvec | input | 2 | Per-destination vector flag |
| iss_didx | input | 16 | Logical destination indices |
| iss_dsize | input | 10 | Destination sizes in bytes |
| iss_load | input | 1 | Instruction is a load |
| iss_atomic | input | 1 | Instruction is an atomic |
| iss_atomic_ret | input | 1 | Atomic returns a value |
| iss_exec | input | 64 | Lane execution mask |
| ex_valid | input | 1 | Execute-complete strobe |
| ex_base | input | 8 | Wavefront base |
| ex_dvec | input | 2 | Per-destination vector flag |
| ex_didx | input | 16 | Logical destination indices |
| ex_dsize | input | 10 | Destination sizes in bytes |
| ex_widest | input | 5 | Largest operand size of the instruction in bytes |
| ex_load | input | 1 | Instruction is a load |
| ex_atomic | input | 1 | Instruction is an atomic |
| ex_memsync | input | 1 | Instruction is a memory sync |
| rt_valid | input | 1 | Load-return strobe |
| rt_base | input | 8 | Wavefront base |
| rt_dvec | input | 2 | Per-destination vector flag |
| rt_didx | input | 16 | Logical destination indices |
| rt_dsize | input | 10 | Destination sizes in bytes |

## Verification
Queries are made with single-register, 8-byte and 16-byte sources, so that the checks separate "first register only" from "whole span". They also probe the register just past a span, which must stay free. A query that sets two source flags with only one of them busy, followed by one with the busy source unflagged, shows whether every flagged source is scanned and whether unflagged ones are ignored. Release timing is probed one cycle before and at the expected edge for each path: the short delay, the long delay and the load return. A reservation that lands on the very edge where a release expires shows whether the reservation wins.

// File: rtl/vreg_busy_board.sv
module vreg_busy_board #(
  parameter int NREGS  = 256,
  parameter int NSRC   = 3,
  parameter int NDST   = 2,
  parameter int LANES  = 64,
  parameter int MAXOPB = 16,
  parameter int SP_LEN = 4,
  parameter int DP_LEN = 8,
  localparam int IW    = $clog2(NREGS),
  localparam int SZW   = $clog2(MAXOPB + 1),
  localparam int CW    = $clog2(DP_LEN + 1),
  localparam int SPAN  = MAXOPB / 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        q_base,
  input  logic [NSRC-1:0]      q_vec,
  input  logic [NSRC*IW-1:0]   q_idx,
  input  logic [NSRC*SZW-1:0]  q_size,
  output logic                 q_ready,
  output logic                 raw_stall,
  input  logic                 iss_valid,
  input  logic [IW-1:0]        iss_base,
  input  logic [NDST-1:0]      iss_dvec,
  input  logic [NDST*IW-1:0]   iss_didx,
  input  logic [NDST*SZW-1:0]  iss_dsize,
  input  logic                 iss_load,
  input  logic                 iss_atomic,
  input  logic                 iss_atomic_ret,
  input  logic [LANES-1:0]     iss_exec,
  input  logic                 ex_valid,
  input  logic [IW-1:0]        ex_base,
  input  logic [NDST-1:0]      ex_dvec,
  input  logic [NDST*IW-1:0]   ex_didx,
  input  logic [NDST*SZW-1:0]  ex_dsize,
  input  logic [SZW-1:0]       ex_widest,
  input  logic                 ex_load,
  input  logic                 ex_atomic,
  input  logic                 ex_memsync,
  input  logic                 rt_valid,
  input  logic [IW-1:0]        rt_base,
  input  logic [NDST-1:0]      rt_dvec,
  input  logic [NDST*IW-1:0]   rt_didx,
  input  logic [NDST*SZW-1:0]  rt_dsize
);

  function automatic int span(input logic [SZW-1:0] sz);
    return (sz <= SZW'(4)) ? 1 : int'(sz >> 2);
  endfunction

  function automatic logic covers(input int r, input logic [IW-1:0] base,
                                  input logic [IW-1:0] idx, input logic [SZW-1:0] sz);
    int s;
    s = int'(base) + int'(idx);
    return (r >= s) && (r < s + span(sz));
  endfunction

  logic [NREGS-1:0] busy;
  logic             rsv_en, rel_en;
  logic [CW-1:0]    ex_dly;

  assign rsv_en = iss_valid && !(iss_atomic && !iss_atomic_ret) && !(iss_load && !(|iss_exec));
  assign rel_en = ex_valid && !ex_load && !ex_atomic && !ex_memsync;
  assign ex_dly = (ex_widest <= SZW'(4)) ? CW'(SP_LEN) : CW'(DP_LEN);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic          b_q;
    logic [CW-1:0] cnt_q;
    logic          rsv_hit, ex_hit, rt_hit;

    always_comb begin
      rsv_hit = 1'b0;
      ex_hit  = 1'b0;
      rt_hit  = 1'b0;
      for (int d = 0; d < NDST; d++) begin
        if (iss_dvec[d] && covers(r, iss_base, iss_didx[d*IW +: IW], iss_dsize[d*SZW +: SZW]))
          rsv_hit = 1'b1;
        if (ex_dvec[d] && covers(r, ex_base, ex_didx[d*IW +: IW], ex_dsize[d*SZW +: SZW]))
          ex_hit = 1'b1;
        if (rt_dvec[d] && covers(r, rt_base, rt_didx[d*IW +: IW], rt_dsize[d*SZW +: SZW]))
          rt_hit = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        b_q   <= 1'b0;
        cnt_q <= '0;
      end else if (rsv_en && rsv_hit) begin
        b_q   <= 1'b1;
        cnt_q <= '0;
      end else if (rt_valid && rt_hit) begin
        cnt_q <= CW'(1);
      end else if (rel_en && ex_hit) begin
        cnt_q <= ex_dly;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) b_q <= 1'b0;
      end
    end

    assign busy[r] = b_q;
  end

  logic stall;
  always_comb begin
    stall = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      for (int j = 0; j < SPAN; j++) begin
        int k;
        k = int'(q_base) + int'(q_idx[s*IW +: IW]) + j;
        if (q_vec[s] && j < span(q_size[s*SZW +: SZW]) && k < NREGS && busy[IW'(k)])
          stall = 1'b1;
      end
    end
  end

  assign raw_stall = stall;
  assign q_ready   = !stall;

endmodule

// File: rtl/vreg_busy_chk.sv
module vreg_busy_chk #(
  parameter int NREGS  = 256,
  parameter int NSRC   = 3,
  parameter int NDST   = 2,
  parameter int IW     = 8,
  parameter int SZW    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NREGS-1:0]    busy,
  input logic [IW-1:0]       q_base,
  input logic [NSRC-1:0]     q_vec,
  input logic [NSRC*IW-1:0]  q_idx,
  input logic [NSRC*SZW-1:0] q_size,
  input logic                q_ready,
  input logic                raw_stall,
  input logic                iss_valid,
  input logic [IW-1:0]       iss_base,
  input logic [NDST-1:0]     iss_dvec,
  input logic [NDST*IW-1:0]  iss_didx,
  input logic [NDST*SZW-1:0] iss_dsize,
  input logic                iss_atomic,
  input logic                iss_atomic_ret
);

  function automatic int span(input logic [SZW-1:0] sz);
    return (sz <= SZW'(4)) ? 1 : int'(sz >> 2);
  endfunction

  logic [IW-1:0] qs0, is0;
  assign qs0 = q_base + q_idx[IW-1:0];
  assign is0 = iss_base + iss_didx[IW-1:0];

  for (genvar d = 0; d < NDST; d++) begin : g_dfit
    // R11
    iss_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_dvec[d]) |->
        (int'(iss_base) + int'(iss_didx[d*IW +: IW]) + span(iss_dsize[d*SZW +: SZW]) <= NREGS));
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_sfit
    // R11
    q_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_vec[s] |->
        (int'(q_base) + int'(q_idx[s*IW +: IW]) + span(q_size[s*SZW +: SZW]) <= NREGS));
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (busy == '0));

  // R4
  rise_only_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |=> ((busy & ~$past(busy)) == '0));

  // R3
  busy_src_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vec[0] && busy[qs0]) |-> (raw_stall && !q_ready));

  // R5
  nonret_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_atomic && !iss_atomic_ret && iss_dvec[0] && !busy[is0]) |=>
      !busy[$past(is0)]);

endmodule

bind vreg_busy_board vreg_busy_chk #(
  .NREGS(NREGS), .NSRC(NSRC), .NDST(NDST), .IW(IW), .SZW(SZW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .q_base(q_base), .q_vec(q_vec), .q_idx(q_idx), .q_size(q_size),
  .q_ready(q_ready), .raw_stall(raw_stall),
  .iss_valid(iss_valid), .iss_base(iss_base), .iss_dvec(iss_dvec),
  .iss_didx(iss_didx), .iss_dsize(iss_dsize),
  .iss_atomic(iss_atomic), .iss_atomic_ret(iss_atomic_ret)
);

// File: tb/sim_vreg_busy_board.sv
`timescale 1ns/1ps
module sim_vreg_busy_board;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  q_base = '0;
  logic [2:0]  q_vec = '0;
  logic [23:0] q_idx = '0;
  logic [14:0] q_size = '0;
  logic        q_ready, raw_stall;
  logic        iss_valid = 0, iss_load = 0, iss_atomic = 0, iss_atomic_ret = 0;
  logic [7:0]  iss_base = '0;
  logic [1:0]  iss_dvec = '0;
  logic [15:0] iss_didx = '0;
  logic [9:0]  iss_dsize = '0;
  logic [63:0] iss_exec = '0;
  logic        ex_valid = 0, ex_load = 0, ex_atomic = 0, ex_memsync = 0;
  logic [7:0]  ex_base = '0;
  logic [1:0]  ex_dvec = '0;
  logic [15:0] ex_didx = '0;
  logic [9:0]  ex_dsize = '0;
  logic [4:0]  ex_widest = '0;
  logic        rt_valid = 0;
  logic [7:0]  rt_base = '0;
  logic [1:0]  rt_dvec = '0;
  logic [15:0] rt_didx = '0;
  logic [9:0]  rt_dsize = '0;

  vreg_busy_board u0 (.*);

  typedef struct { bit exp; string tag; } item_t;
  item_t sbq[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (q_ready !== it.exp || raw_stall !== !it.exp) begin
        errors++;
        $display("FAIL %s: q_ready=%0b raw_stall=%0b expected q_ready=%0b raw_stall=%0b",
                 it.tag, q_ready, raw_stall, it.exp, !it.exp);
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wait_n(input int n); repeat (n) step(); endtask

  task automatic probe(input [7:0] b, input [7:0] i0, input [4:0] s0,
                       input [7:0] i1, input [4:0] s1, input [2:0] v,
                       input bit exp, input string tag);
    q_base = b; q_vec = v;
    q_idx = {8'd0, i1, i0}; q_size = {5'd0, s1, s0};
    sbq.push_back('{exp, tag});
    @(negedge clk); #1;
  endtask

  task automatic issue(input [7:0] b, input [7:0] i0, input [4:0] s0,
                       input [7:0] i1, input [4:0] s1, input [1:0] dv,
                       input bit ld, input bit at, input bit ar, input [63:0] ex);
    iss_valid = 1; iss_base = b; iss_didx = {i1, i0}; iss_dsize = {s1, s0};
    iss_dvec = dv; iss_load = ld; iss_atomic = at; iss_atomic_ret = ar; iss_exec = ex;
    step();
    iss_valid = 0;
  endtask

  task automatic complete(input [7:0] b, input [7:0] i0, input [4:0] s0,
                          input [4:0] w, input bit ld, input bit at, input bit ms);
    ex_valid = 1; ex_base = b; ex_didx = {8'd0, i0}; ex_dsize = {5'd0, s0};
    ex_dvec = 2'b01; ex_widest = w; ex_load = ld; ex_atomic = at; ex_memsync = ms;
    step();
    ex_valid = 0;
  endtask

  task automatic ret(input [7:0] b, input [7:0] i0, input [4:0] s0);
    rt_valid = 1; rt_base = b; rt_didx = {8'd0, i0}; rt_dsize = {5'd0, s0}; rt_dvec = 2'b01;
    step();
    rt_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    step();
    probe(0, 0, 16, 0, 0, 3'b001, 1, "R1 registers free after reset");
    probe(0, 0, 16, 0, 0, 3'b000, 1, "R1 query without vector sources");

    issue(16, 4, 8, 12, 4, 2'b11, 0, 0, 0, '1);
    probe(16, 5, 4, 0, 0, 3'b001, 0, "R4 second register of 8-byte destination");
    probe(16, 6, 4, 0, 0, 3'b001, 1, "R2 register past the span");
    probe(16, 3, 16, 0, 0, 3'b001, 0, "R2 16-byte source overlapping span");
    probe(16, 12, 4, 0, 0, 3'b001, 0, "R4 second destination reserved");
    probe(100, 4, 4, 0, 0, 3'b001, 1, "R2 other wavefront base maps elsewhere");
    probe(16, 0, 4, 12, 4, 3'b011, 0, "R3 busy second source stalls");
    probe(16, 0, 4, 12, 4, 3'b001, 1, "R3 unflagged source ignored");

    complete(16, 4, 8, 4, 0, 0, 0);
    wait_n(3);
    probe(16, 5, 4, 0, 0, 3'b001, 0, "R7 short delay still busy");
    step();
    probe(16, 4, 8, 0, 0, 3'b001, 1, "R7 short delay released");

    complete(16, 12, 4, 8, 0, 0, 0);
    wait_n(7);
    probe(16, 12, 4, 0, 0, 3'b001, 0, "R7 long delay still busy");
    step();
    probe(16, 12, 4, 0, 0, 3'b001, 1, "R7 long delay released");

    issue(16, 30, 4, 0, 0, 2'b01, 0, 1, 0, '1);
    probe(16, 30, 4, 0, 0, 3'b001, 1, "R5 non-returning atomic reserves nothing");
    issue(16, 31, 4, 0, 0, 2'b01, 0, 1, 1, '1);
    probe(16, 31, 4, 0, 0, 3'b001, 0, "R4 returning atomic reserves");
    complete(16, 31, 4, 4, 0, 1, 0);
    wait_n(10);
    probe(16, 31, 4, 0, 0, 3'b001, 0, "R8 atomic completion frees nothing");
    ret(16, 31, 4);
    probe(16, 31, 4, 0, 0, 3'b001, 0, "R9 busy on edge sampling return");
    step();
    probe(16, 31, 4, 0, 0, 3'b001, 1, "R9 released one edge after return");

    issue(16, 40, 8, 0, 0, 2'b01, 1, 0, 0, '0);
    probe(16, 40, 8, 0, 0, 3'b001, 1, "R6 zero-mask load reserves nothing");
    issue(16, 40, 8, 0, 0, 2'b01, 1, 0, 0, 64'h8000_0000_0000_0000);
    probe(16, 41, 4, 0, 0, 3'b001, 0, "R4 load with one lane reserves");
    complete(16, 40, 8, 8, 1, 0, 0);
    wait_n(10);
    probe(16, 40, 8, 0, 0, 3'b001, 0, "R8 load completion frees nothing");
    complete(16, 40, 8, 4, 0, 0, 1);
    wait_n(10);
    probe(16, 40, 8, 0, 0, 3'b001, 0, "R8 memory sync completion frees nothing");
    ret(16, 40, 8);
    step();
    probe(16, 40, 8, 0, 0, 3'b001, 1, "R9 load return frees both registers");

    issue(16, 50, 4, 0, 0, 2'b01, 0, 0, 0, '1);
    complete(16, 50, 4, 4, 0, 0, 0);
    wait_n(3);
    issue(16, 50, 4, 0, 0, 2'b01, 0, 0, 0, '1);
    probe(16, 50, 4, 0, 0, 3'b001, 0, "R10 reservation beats expiring release");
    wait_n(6);
    probe(16, 50, 4, 0, 0, 3'b001, 0, "R10 pending release cancelled");
    complete(16, 50, 4, 4, 0, 0, 0);
    wait_n(4);
    probe(16, 50, 4, 0, 0, 3'b001, 1, "R7 release after re-reservation");

    issue(16, 60, 16, 0, 0, 2'b01, 0, 0, 0, '1);
    rst_n = 0;
    step();
    rst_n = 1;
    probe(16, 60, 16, 0, 0, 3'b001, 1, "R1 reset clears reservations");

    wait_n(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule